// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges each incoming Ethernet frame by its 48-bit destination address and tells the receive path whether to keep it. The receive logic presents the six destination bytes with a one-cycle strobe. One clock later the filter returns a registered verdict with a set of classification flags: broadcast, group (multicast), hash-bin hit and exact-slot hit, plus the index of the slot that matched. These flags are meant to be copied into the per-frame receive status word.

Software programs the filter through a simple 16-bit write port. The filter holds a control word with a promiscuous enable and a hash enable. It has four exact-match address slots, three 16-bit words each. Slot 0 is the station's own address and the other slots are group entries. It also has a 64-bin hash table, four 16-bit words, indexed by the six most significant bits of the Ethernet CRC-32 of the destination address. Group traffic passes on an exact match with one of the group slots or through an enabled hash bin. Unicast traffic passes only on the station address. Broadcast always passes, and promiscuous mode passes everything.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset the control word, hash table and every slot read as zero, and `res_valid`, `accept` and all flags and `slot_idx` are 0.
- R2: A strobe on `da_valid` produces `res_valid` high for exactly one cycle on the following clock edge, with the verdict for that address. While no strobe arrives the verdict outputs keep their last values.
- R3: The broadcast address (all 48 bits one) is always accepted with `is_bcast`=1, `is_mcast`=0, `hash_hit`=0 and `slot_hit`=0.
- R4: An address whose first byte has bit 0 clear is unicast. With promiscuous mode off it is accepted only when it equals slot 0, which gives `slot_hit`=1 and `slot_idx`=0. Any other unicast address is rejected.
- R5: Control bit 5 enables promiscuous mode. In that mode every address is accepted, and the flags are still reported as they would be without promiscuous mode.
- R6: A group address (first byte bit 0 set, not broadcast) gives `is_mcast`=1. It is accepted on an exact match with slot 1, 2 or 3, and `slot_idx` gives the lowest matching slot. When no slot hits, `slot_idx` is 0.
- R7: Control bit 8 enables the hash. The bin is the top six bits of the CRC-32 (polynomial 04C11DB7, register preset to all ones, no final inversion, address bits fed in wire order). Bin bits [5:4] select the hash word and bits [3:0] select the bit within it. A group address with the hash enabled and its bin set gives `hash_hit`=1 and is accepted. With the hash disabled, `hash_hit` is 0.
- R8: Register map: control at address 0, hash word k at 4+k, and word w of slot s at 16+4s+w. For a slot, word 0 holds {byte1,byte0}, word 1 holds {byte3,byte2} and word 2 holds {byte5,byte4}, where byte0 is the first byte on the wire and occupies `da[7:0]`.
- R9: A slot cleared to zero still takes part in matching. A zeroed slot 0 matches the all-zero unicast address. A zeroed group slot can never match a group address.
- R10: A register write in the same cycle as a `da_valid` strobe does not affect that strobe's verdict. The new value applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW (5) | Register word address |
| cfg_wdata | input | 16 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits [7:0] |
| res_valid | output | 1 | Verdict strobe, one cycle after `da_valid` |
| accept | output | 1 | Frame accepted |
| is_bcast | output | 1 | Address is broadcast |
| is_mcast | output | 1 | Address is a group address other than broadcast |
| hash_hit | output | 1 | Enabled hash bin hit |
| slot_hit | output | 1 | Exact match on an eligible slot |
| slot_idx | output | clog2(NSLOT) (2) | Index of the matching slot |

## Verification
A corrupted slot word or a wrong byte order in the slot layout shows up at the ports on the very next verdict. A unicast probe that should match flips to reject, or a single-bit-flipped address is wrongly accepted. A wrong CRC bit, a wrong bin-to-word mapping or a stuck hash-table bit shows up as a wrong `hash_hit` for some group address. For that reason the bench sweeps hundreds of group addresses across several bin patterns, so every table word and most bins are reached. A slip in the strobe pipeline or in the use of stale register values shows up in the cycle right after the strobe: `res_valid` fails to pulse, the verdict fails to hold, or a same-cycle write leaks into the result.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
   localparam logic [31:0] CRC_POLY      = 32'h04C1_1DB7;
   localparam int          WORD_W        = 16;
   localparam int          MAC_W         = 48;
   localparam int          WORDS_PER_MAC = MAC_W / WORD_W;
   localparam int          HASH_WORDS    = 4;
   localparam int          HASH_BITS     = 6;
   localparam int          HASH_BINS     = HASH_WORDS * WORD_W;
   localparam int          CTRL_PROM_BIT = 5;
   localparam int          CTRL_HASH_BIT = 8;
   localparam int          CTRL_ADDR     = 0;
   localparam int          HASH_BASE     = 4;
   localparam int          SLOT_BASE     = 16;
   localparam int          SLOT_STRIDE   = 4;
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
   import dafilt_pkg::*;
#(
   parameter int NSLOT = 4,
   parameter int AW    = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [AW-1:0]                 addr,
   input  logic [WORD_W-1:0]             wdata,
   output logic                          prom,
   output logic                          hash_en,
   output logic [HASH_BINS-1:0]          hash_tbl,
   output logic [NSLOT-1:0][MAC_W-1:0]   slots
);
   // control word: only the two defined bits are stored
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prom    <= 1'b0;
         hash_en <= 1'b0;
      end else if (we && addr == AW'(CTRL_ADDR)) begin
         prom    <= wdata[CTRL_PROM_BIT];
         hash_en <= wdata[CTRL_HASH_BIT];
      end
   end

   for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (we && addr == AW'(HASH_BASE + k))
            word_q <= wdata;
      end
      assign hash_tbl[k*WORD_W +: WORD_W] = word_q;
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      for (genvar w = 0; w < WORDS_PER_MAC; w++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (we && addr == AW'(SLOT_BASE + SLOT_STRIDE*s + w))
               word_q <= wdata;
         end
         assign slots[s][w*WORD_W +: WORD_W] = word_q;
      end
   end
endmodule

// File: rtl/dafilt_hash.sv
module dafilt_hash
   import dafilt_pkg::*;
(
   input  logic [MAC_W-1:0]     da,
   input  logic [HASH_BINS-1:0] tbl,
   output logic [HASH_BITS-1:0] bin,
   output logic                 bin_set
);
   logic [31:0] crc;

   // serial CRC-32 unrolled over the address bits in wire order
   always_comb begin
      logic fb;
      crc = '1;
      for (int k = 0; k < MAC_W; k++) begin
         fb  = crc[31] ^ da[k];
         crc = {crc[30:0], 1'b0};
         if (fb) crc = crc ^ CRC_POLY;
      end
   end

   assign bin     = crc[31 -: HASH_BITS];
   assign bin_set = tbl[bin];
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
   import dafilt_pkg::*;
#(
   parameter int NSLOT = 4,
   parameter int IDX_W = 2
) (
   input  logic [MAC_W-1:0]             da,
   input  logic [NSLOT-1:0][MAC_W-1:0]  slots,
   output logic                         hit,
   output logic [IDX_W-1:0]             idx
);
   logic [NSLOT-1:0] eq;
   logic             grp;

   assign grp = da[0] && !(&da);

   // slot 0 serves unicast only, the rest serve group addresses only
   for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
      if (s == 0) begin : g_station
         assign eq[s] = !da[0] && (slots[s] == da);
      end else begin : g_group
         assign eq[s] = grp && (slots[s] == da);
      end
   end

   always_comb begin
      idx = '0;
      for (int s = NSLOT - 1; s >= 0; s--)
         if (eq[s]) idx = IDX_W'(s);
   end

   assign hit = |eq;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import dafilt_pkg::*;
#(
   parameter int NSLOT = 4,
   parameter int AW    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [AW-1:0]             cfg_addr,
   input  logic [15:0]               cfg_wdata,
   input  logic                      da_valid,
   input  logic [47:0]               da,
   output logic                      res_valid,
   output logic                      accept,
   output logic                      is_bcast,
   output logic                      is_mcast,
   output logic                      hash_hit,
   output logic                      slot_hit,
   output logic [$clog2(NSLOT)-1:0]  slot_idx
);
   localparam int IDX_W    = $clog2(NSLOT);
   localparam int MAP_TOP  = SLOT_BASE + SLOT_STRIDE*(NSLOT-1) + WORDS_PER_MAC - 1;

   if (NSLOT < 2 || NSLOT > 4) begin : g_bad_nslot
      $error("rx_dest_filter: NSLOT must lie in 2..4");
   end
   if (MAP_TOP >= (1 << AW)) begin : g_bad_aw
      $error("rx_dest_filter: AW too narrow for the register map");
   end

   logic                         prom, hash_en;
   logic [HASH_BINS-1:0]         hash_tbl;
   logic [NSLOT-1:0][MAC_W-1:0]  slots;
   logic [HASH_BITS-1:0]         bin;
   logic                         bin_set;
   logic                         m_hit;
   logic [IDX_W-1:0]             m_idx;

   dafilt_regs #(.NSLOT(NSLOT), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .prom(prom), .hash_en(hash_en), .hash_tbl(hash_tbl), .slots(slots)
   );

   dafilt_hash u_hash (
      .da(da), .tbl(hash_tbl), .bin(bin), .bin_set(bin_set)
   );

   dafilt_match #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_match (
      .da(da), .slots(slots), .hit(m_hit), .idx(m_idx)
   );

   logic c_bc, c_mc, c_uc, c_hh, c_acc;
   assign c_bc  = &da;
   assign c_mc  = da[0] && !c_bc;
   assign c_uc  = !da[0];
   assign c_hh  = c_mc && hash_en && bin_set;
   assign c_acc = prom || c_bc || (c_uc && m_hit) || (c_mc && (m_hit || c_hh));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         accept    <= 1'b0;
         is_bcast  <= 1'b0;
         is_mcast  <= 1'b0;
         hash_hit  <= 1'b0;
         slot_hit  <= 1'b0;
         slot_idx  <= '0;
      end else begin
         res_valid <= da_valid;
         if (da_valid) begin
            accept   <= c_acc;
            is_bcast <= c_bc;
            is_mcast <= c_mc;
            hash_hit <= c_hh;
            slot_hit <= m_hit;
            slot_idx <= m_idx;
         end
      end
   end
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             da_valid,
   input logic [47:0]      da,
   input logic             prom,
   input logic             hash_en,
   input logic             res_valid,
   input logic             accept,
   input logic             is_bcast,
   input logic             is_mcast,
   input logic             hash_hit,
   input logic             slot_hit,
   input logic [IDX_W-1:0] slot_idx
);
   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid); // R2
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !res_valid && $stable(accept) && $stable(slot_idx)); // R2
   AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && (&da) |=> accept && is_bcast && !is_mcast); // R3
   AST_UNICAST_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && !da[0] && !prom |=> accept == slot_hit); // R4
   AST_PROM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && prom |=> accept); // R5
   AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !slot_hit |-> slot_idx == '0); // R6
   AST_HASH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && !hash_en |=> !hash_hit); // R7
endmodule

bind rx_dest_filter dafilt_chk #(.IDX_W($clog2(NSLOT))) u_chk (
   .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
   .prom(prom), .hash_en(hash_en), .res_valid(res_valid), .accept(accept),
   .is_bcast(is_bcast), .is_mcast(is_mcast), .hash_hit(hash_hit),
   .slot_hit(slot_hit), .slot_idx(slot_idx)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [4:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic        da_valid;
   logic [47:0] da;
   logic        res_valid, accept, is_bcast, is_mcast, hash_hit, slot_hit;
   logic [1:0]  slot_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_dest_filter uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
      .res_valid(res_valid), .accept(accept), .is_bcast(is_bcast),
      .is_mcast(is_mcast), .hash_hit(hash_hit), .slot_hit(slot_hit),
      .slot_idx(slot_idx)
   );

   // bench-side view of the programmed registers
   logic        sh_prom, sh_hen;
   logic [63:0] sh_tbl;
   logic [47:0] sh_slot [4];
   int          n_run = 0, n_fail = 0;
   bit          done = 0;

   function automatic logic [5:0] ref_bin(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int k = 0; k < 48; k++) begin
         logic b = c[31] ^ a[k];
         c = c << 1;
         if (b) c = c ^ 32'h04C1_1DB7;
      end
      return c[31:26];
   endfunction

   // {accept, bcast, mcast, hash_hit, slot_hit, idx[1:0]}
   function automatic logic [6:0] ref_out(input logic [47:0] a);
      logic bc = (a == 48'hFFFF_FFFF_FFFF);
      logic mc = a[0] && !bc;
      logic uc = !a[0];
      logic [5:0] bn = ref_bin(a);
      logic hh = mc && sh_hen && sh_tbl[bn[5:4]*16 + bn[3:0]];
      logic sh = 1'b0;
      logic [1:0] ix = 2'd0;
      if (uc && sh_slot[0] == a) sh = 1'b1;
      if (mc) begin
         for (int s = 3; s >= 1; s--)
            if (sh_slot[s] == a) begin sh = 1'b1; ix = 2'(s); end
      end
      return {sh_prom || bc || (uc && sh) || (mc && (sh || hh)), bc, mc, hh, sh, ix};
   endfunction

   function automatic logic [6:0] got();
      return {accept, is_bcast, is_mcast, hash_hit, slot_hit, slot_idx};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic shadow_write(input logic [4:0] a, input logic [15:0] d);
      if (a == 5'd0) begin sh_prom = d[5]; sh_hen = d[8]; end
      else if (a >= 5'd4 && a <= 5'd7) sh_tbl[(a-4)*16 +: 16] = d;
      else if (a >= 5'd16 && a[1:0] != 2'd3) sh_slot[(a-16)/4][a[1:0]*16 +: 16] = d;
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      shadow_write(a, d);
   endtask

   task automatic set_slot(input int s, input logic [47:0] a);
      for (int w = 0; w < 3; w++) wr(5'(16 + 4*s + w), a[w*16 +: 16]);
   endtask

   task automatic set_ctrl(input logic p, input logic h);
      wr(5'd0, {7'b0, h, 2'b0, p, 5'b0});
   endtask

   task automatic set_tbl(input logic [63:0] t);
      for (int k = 0; k < 4; k++) wr(5'(4 + k), t[k*16 +: 16]);
   endtask

   task automatic probe(input string req, input logic [47:0] a);
      logic [6:0] e = ref_out(a);
      @(negedge clk);
      da = a; da_valid = 1'b1;
      @(negedge clk);
      da_valid = 1'b0; da = ~a;
      chk({req, " strobe"}, 32'(res_valid), 32'd1);
      chk(req, 32'(got()), 32'(e));
      @(negedge clk);
      chk("R2 hold", 32'({res_valid, got()}), 32'({1'b0, e}));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] st, g1, g2, a;
      sh_prom = 0; sh_hen = 0; sh_tbl = '0;
      for (int s = 0; s < 4; s++) sh_slot[s] = '0;
      rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; da_valid = 0; da = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset outputs", 32'({res_valid, got()}), 32'd0);
      // zeroed slot 0 matches the zero address: R9, and shows slots reset to zero: R1
      probe("R9 zero station slot", 48'h0);
      probe("R1 group with empty tables", 48'h0000_0000_0001);

      st = 48'h5544_3322_1102;           // bytes 02:11:22:33:44:55
      set_slot(0, st);
      probe("R8 station word layout", st);
      probe("R4 station match", st);
      for (int b = 1; b < 48; b++) probe("R4 unicast one bit off", st ^ (48'd1 << b));
      probe("R9 zero no longer matches", 48'h0);
      probe("R3 broadcast", 48'hFFFF_FFFF_FFFF);

      set_ctrl(1'b1, 1'b0);
      probe("R5 promiscuous foreign unicast", 48'h9988_7766_5500);
      probe("R5 promiscuous station flags", st);
      probe("R5 promiscuous group", 48'h1234_0000_0003);
      set_ctrl(1'b0, 1'b0);
      probe("R4 foreign unicast after promiscuous off", 48'h9988_7766_5500);

      g1 = 48'h0100_005E_0001;           // 01:00:5E:00:00:01
      g2 = 48'h0E00_00C2_8001;           // 01:80:C2:00:00:0E
      set_slot(1, g1);
      set_slot(2, g2);
      set_slot(3, g2);
      probe("R6 group slot1", g1);
      probe("R6 lowest slot wins", g2);
      probe("R6 group miss", 48'h0F00_00C2_8001);
      probe("R6 station address with group bit", st | 48'd1);
      set_slot(2, 48'h0);
      probe("R6 slot3 after slot2 cleared", g2);
      probe("R9 zeroed group slot vs group", 48'h0000_0000_0001);

      // hash sweeps: disabled, then two bin patterns enabled
      set_tbl(64'hFFFF_FFFF_FFFF_FFFF);
      for (int i = 0; i < 64; i++) begin
         a = {8'(i), 8'(i*7), 8'h33, 8'h5E, 8'h00, 8'h01};
         probe("R7 hash disabled", a);
      end
      set_ctrl(1'b0, 1'b1);
      set_tbl(64'hA5A5_0F0F_3C3C_8001);
      for (int i = 0; i < 256; i++) begin
         a = {8'(i), 8'(i*7), 8'h33, 8'h5E, 8'h00, 8'h01};
         probe("R7 hash pattern A", a);
      end
      set_tbl(64'h5A5A_F0F0_C3C3_7FFE);
      for (int i = 0; i < 256; i++) begin
         a = {8'(i*13), 8'(i), 8'h44, 8'h5E, 8'h00, 8'h03};
         probe("R7 hash pattern B", a);
      end
      probe("R7 unicast ignores hash", 48'h1111_2222_3300);

      // R10: write in the strobe cycle uses the old contents
      @(negedge clk);
      begin
         logic [6:0] e = ref_out(st);
         cfg_we = 1'b1; cfg_addr = 5'd16; cfg_wdata = 16'hBEEF & 16'hFFFE;
         da = st; da_valid = 1'b1;
         @(negedge clk);
         cfg_we = 1'b0; da_valid = 1'b0;
         shadow_write(5'd16, 16'hBEEE);
         chk("R10 same-cycle write uses old slot", 32'(got()), 32'(e));
      end
      probe("R10 new slot value applies next", st);
      probe("R10 rewritten slot matches", {st[47:16], 16'hBEEE});

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule